// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block owns start-up and periodic refresh for an asynchronous DRAM. After reset it waits out a fixed power-up pause, then runs a fixed number of warm-up refresh cycles. Only after the last of these finishes does it raise `ready`, which tells the access sequencer that normal reads and writes may begin.

In normal operation a rate timer produces one refresh tick per row interval. Ticks that have not yet been served are counted, so a busy access sequencer delays refresh but does not lose it. Whenever refresh work is outstanding, the scheduler raises a request. The access sequencer answers with a grant. For the following fixed number of cycles the scheduler owns the bus and drives the row strobe, the column strobe and the write enable.

Each refresh uses one of two styles:
- **CAS-before-RAS:** the DRAM's own internal row counter picks the row.
- **RAS-only:** the scheduler presents a row address from its own counter.

In both styles write enable is held high, so a refresh cycle can never be mistaken for a test-mode entry.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and for `PAUSE_CYC` cycles after its release, `refReq`, `ready` and `busOwn` are 0, `rasN`/`casN`/`weN` are 1 and `rowAddr` is 0.
- R2: After the pause, exactly `WARM_CNT` (default 8) refresh cycles are performed. `ready` rises on the clock edge that ends the last of them and never falls again before reset.
- R3: Once `ready` is high, a refresh tick occurs every `INTERVAL` = `REF_PERIOD_CYC / 2**ROW_BITS - GUARD_CYC` cycles. Unserved ticks are counted up to `PEND_MAX`, saturating there, and each granted cycle consumes one.
- R4: A CAS-before-RAS cycle (`refMode` = 0) drives `casN` low from phase 0 through phase `SETUP_CYC+TRAS_CYC-1`, drives `rasN` low from phase `SETUP_CYC` through phase `SETUP_CYC+TRAS_CYC-1`, and then holds both high for `TRP_CYC` cycles.
- R5: A RAS-only cycle (`refMode` = 1) has the same `rasN` timing as R4 with `casN` held high throughout.
- R6: `weN` is 1 in every cycle.
- R7: `refReq` is 1 exactly when the bus is not owned and either warm-up is in progress or the pending count is non-zero. A cycle with `refReq` and `busGrant` both 1 at a clock edge starts the refresh cycle (phase 0) in the next cycle.
- R8: `rowAddr` increments by one, wrapping modulo `2**ROW_BITS`, at the end of each RAS-only cycle, and is unchanged by CAS-before-RAS cycles.
- R9: `busOwn` is 1 for exactly `SETUP_CYC+TRAS_CYC+TRP_CYC` cycles per refresh. Whenever `busOwn` is 0, `rasN` and `casN` are 1.
- R10: The refresh style is taken from `refMode` on the granting edge. Changes of `refMode` during a cycle do not affect that cycle's strobes or row step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busGrant | input | 1 | Grant from the access sequencer |
| refMode | input | 1 | Refresh style: 0 = CAS-before-RAS, 1 = RAS-only |
| refReq | output | 1 | Refresh request to the access sequencer |
| ready | output | 1 | Start-up sequence finished; normal access allowed |
| busOwn | output | 1 | Scheduler is driving the DRAM strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low (held high) |
| rowAddr | output | ROW_BITS | Row address for RAS-only refresh |

## Verification
The following faults in internal state show up at the ports:

- **Phase counter off by one:** the refresh cycle comes out stretched or shortened. The per-clock comparison catches the wrong `rasN` edge or the wrong `busOwn` length within that same refresh cycle.
- **Lost or duplicated pending tick:** `refReq` appears one interval early or late, or stays high one cycle too long after a drained backlog. The saturation phase of the bench makes an overflowing count visible as an extra refresh cycle.
- **Wrong warm-up count:** `ready` moves by a full refresh cycle.
- **Wrong row step:** `rowAddr` differs at the edge that ends the first affected RAS-only cycle.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WARM  = 2'd1,
    ST_RUN   = 2'd2
  } schedState_e;

  typedef enum logic {
    STYLE_CBR     = 1'b0,
    STYLE_RASONLY = 1'b1
  } refStyle_e;

  // strobes from control to datapath
  typedef struct packed {
    logic runTimer;  // normal operation: rate timer counts
    logic takeRun;   // a granted cycle consumes one pending tick
    logic rowStep;   // a RAS-only cycle just ended
  } dpStrobe_t;

endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int ROW_BITS       = 12,
  parameter int REF_PERIOD_CYC = 8000000,
  parameter int GUARD_CYC      = 16,
  parameter int PEND_MAX       = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobes,
  output logic                pendNonZero,
  output logic [ROW_BITS-1:0] rowAddr
);

  localparam int ROWS     = 1 << ROW_BITS;
  localparam int INTERVAL = REF_PERIOD_CYC / ROWS - GUARD_CYC;
  localparam int TW       = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int NW       = $clog2(PEND_MAX + 1);
  localparam logic [TW-1:0] TIMER_LAST = TW'(INTERVAL - 1);
  localparam logic [NW-1:0] PEND_TOP   = NW'(PEND_MAX);

  logic [TW-1:0]       timerCnt;
  logic [NW-1:0]       pending;
  logic [ROW_BITS-1:0] rowCnt;
  logic                tick;

  assign tick = strobes.runTimer && (timerCnt == TIMER_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (strobes.runTimer) begin
      timerCnt <= tick ? '0 : timerCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
    end else begin
      unique case ({tick, strobes.takeRun})
        2'b10:   if (pending != PEND_TOP) pending <= pending + 1'b1;
        2'b01:   pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rowCnt <= '0;
    else if (strobes.rowStep) rowCnt <= rowCnt + 1'b1;
  end

  assign pendNonZero = (pending != '0);
  assign rowAddr     = rowCnt;

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int PAUSE_CYC = 25000,
  parameter int WARM_CNT  = 8,
  parameter int SETUP_CYC = 2,
  parameter int TRAS_CYC  = 7,
  parameter int TRP_CYC   = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busGrant,
  input  logic      refMode,
  input  logic      pendNonZero,
  output dpStrobe_t strobes,
  output logic      refReq,
  output logic      ready,
  output logic      busOwn,
  output logic      rasN,
  output logic      casN,
  output logic      weN
);

  localparam int CYC_LEN = SETUP_CYC + TRAS_CYC + TRP_CYC;
  localparam int PW  = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
  localparam int PHW = $clog2(CYC_LEN);
  localparam int WW  = $clog2(WARM_CNT + 1);
  localparam logic [PW-1:0]  PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [PHW-1:0] PH_LAST    = PHW'(CYC_LEN - 1);
  localparam logic [PHW-1:0] RAS_ON     = PHW'(SETUP_CYC);
  localparam logic [PHW-1:0] RAS_OFF    = PHW'(SETUP_CYC + TRAS_CYC);
  localparam logic [WW-1:0]  WARM_LAST  = WW'(WARM_CNT - 1);

  schedState_e    state;
  refStyle_e      style;
  logic [PW-1:0]  pauseCnt;
  logic [PHW-1:0] phase;
  logic [WW-1:0]  warmCnt;
  logic           busy;
  logic           take;
  logic           done;

  assign refReq = !busy && ((state == ST_WARM) || ((state == ST_RUN) && pendNonZero));
  assign take   = refReq && busGrant;
  assign done   = busy && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_PAUSE;
      pauseCnt <= '0;
      warmCnt  <= '0;
    end else begin
      unique case (state)
        ST_PAUSE: begin
          if (pauseCnt == PAUSE_LAST) state <= ST_WARM;
          else pauseCnt <= pauseCnt + 1'b1;
        end
        ST_WARM: begin
          if (done) begin
            warmCnt <= warmCnt + 1'b1;
            if (warmCnt == WARM_LAST) state <= ST_RUN;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      phase <= '0;
      style <= STYLE_CBR;
    end else if (take) begin
      busy  <= 1'b1;
      phase <= '0;
      style <= refStyle_e'(refMode);
    end else if (done) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (busy) begin
      phase <= phase + 1'b1;
    end
  end

  // strobe shaping: CAS leads RAS in the CAS-before-RAS style
  assign rasN   = !(busy && (phase >= RAS_ON) && (phase < RAS_OFF));
  assign casN   = !(busy && (style == STYLE_CBR) && (phase < RAS_OFF));
  assign weN    = 1'b1;
  assign busOwn = busy;
  assign ready  = (state == ST_RUN);

  assign strobes.runTimer = (state == ST_RUN);
  assign strobes.takeRun  = take && (state == ST_RUN);
  assign strobes.rowStep  = done && (style == STYLE_RASONLY);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refresh_pkg::*;
#(
  parameter int PAUSE_CYC      = 25000,
  parameter int WARM_CNT       = 8,
  parameter int ROW_BITS       = 12,
  parameter int REF_PERIOD_CYC = 8000000,
  parameter int GUARD_CYC      = 16,
  parameter int PEND_MAX       = 8,
  parameter int SETUP_CYC      = 2,
  parameter int TRAS_CYC       = 7,
  parameter int TRP_CYC        = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busGrant,
  input  logic                refMode,
  output logic                refReq,
  output logic                ready,
  output logic                busOwn,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic [ROW_BITS-1:0] rowAddr
);

  dpStrobe_t strobes;
  logic      pendNonZero;

  refresh_ctrl #(
    .PAUSE_CYC(PAUSE_CYC), .WARM_CNT(WARM_CNT),
    .SETUP_CYC(SETUP_CYC), .TRAS_CYC(TRAS_CYC), .TRP_CYC(TRP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .refMode(refMode),
    .pendNonZero(pendNonZero), .strobes(strobes), .refReq(refReq),
    .ready(ready), .busOwn(busOwn), .rasN(rasN), .casN(casN), .weN(weN)
  );

  refresh_dp #(
    .ROW_BITS(ROW_BITS), .REF_PERIOD_CYC(REF_PERIOD_CYC),
    .GUARD_CYC(GUARD_CYC), .PEND_MAX(PEND_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pendNonZero(pendNonZero), .rowAddr(rowAddr)
  );

endmodule

// File: rtl/refresh_sched_checker.sv
module refresh_sched_checker #(
  parameter int ROW_BITS = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                refReq,
  input logic                ready,
  input logic                busOwn,
  input logic                rasN,
  input logic                casN,
  input logic                weN,
  input logic [ROW_BITS-1:0] rowAddr
);

  assert_we_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    weN);

  assert_idle_strobes_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busOwn |-> (rasN && casN));

  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !casN) |-> $past(!casN));

  assert_no_req_while_owning_R7: assert property (@(posedge clk) disable iff (!rstN)
    busOwn |-> !refReq);

  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  assert_row_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rowAddr) |-> (rowAddr == $past(rowAddr) + 1'b1));

  assert_no_ras_without_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> busOwn);

endmodule

bind dram_refresh_sched refresh_sched_checker #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .refReq(refReq), .ready(ready), .busOwn(busOwn),
  .rasN(rasN), .casN(casN), .weN(weN), .rowAddr(rowAddr)
);

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;

  localparam int PAUSE  = 50;
  localparam int WARM   = 8;
  localparam int RB     = 3;
  localparam int PERIOD = 400;
  localparam int GUARD  = 4;
  localparam int PMAX   = 4;
  localparam int SU     = 2;
  localparam int TR     = 7;
  localparam int TP     = 4;
  localparam int LEN    = SU + TR + TP;
  localparam int IVAL   = PERIOD / (1 << RB) - GUARD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busGrant = 1'b0;
  logic refMode = 1'b0;
  logic refReq, ready, busOwn, rasN, casN, weN;
  logic [RB-1:0] rowAddr;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .WARM_CNT(WARM), .ROW_BITS(RB), .REF_PERIOD_CYC(PERIOD),
    .GUARD_CYC(GUARD), .PEND_MAX(PMAX), .SETUP_CYC(SU), .TRAS_CYC(TR), .TRP_CYC(TP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .refMode(refMode),
    .refReq(refReq), .ready(ready), .busOwn(busOwn), .rasN(rasN),
    .casN(casN), .weN(weN), .rowAddr(rowAddr)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int mStage, mPause, mBusy, mPhase, mWarm, mStyle, mTimer, mPend, mRow;
  int mReq, mTake, mDone, mTick;

  function automatic int modelReq();
    return (mBusy == 0 && (mStage == 1 || (mStage == 2 && mPend > 0))) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mStage = 0; mPause = 0; mBusy = 0; mPhase = 0; mWarm = 0;
      mStyle = 0; mTimer = 0; mPend = 0; mRow = 0;
    end else begin
      mReq  = modelReq();
      mTake = mReq && busGrant;
      mDone = (mBusy == 1 && mPhase == LEN - 1) ? 1 : 0;
      mTick = (mStage == 2 && mTimer == IVAL - 1) ? 1 : 0;
      if (mStage == 2) mTimer = mTick ? 0 : mTimer + 1;
      if (mTick && !(mTake && mStage == 2)) mPend = (mPend < PMAX) ? mPend + 1 : PMAX;
      else if (!mTick && mTake && mStage == 2) mPend = mPend - 1;
      if (mDone && mStyle == 1) mRow = (mRow + 1) % (1 << RB);
      if (mStage == 0) begin
        if (mPause == PAUSE - 1) mStage = 1; else mPause++;
      end else if (mStage == 1 && mDone) begin
        mWarm++;
        if (mWarm == WARM) mStage = 2;
      end
      if (mTake) begin mBusy = 1; mPhase = 0; mStyle = refMode; end
      else if (mDone) begin mBusy = 0; mPhase = 0; end
      else if (mBusy == 1) mPhase++;
    end
  end

  int expRas, expCas;
  bit compareOn = 0;

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (compareOn) begin
      expRas = (mBusy == 1 && mPhase >= SU && mPhase < SU + TR) ? 0 : 1;
      expCas = (mBusy == 1 && mStyle == 0 && mPhase < SU + TR) ? 0 : 1;
      check(mStyle == 0 ? "R4 rasN" : "R5 rasN", int'(rasN), expRas);
      check(mStyle == 0 ? "R4 casN" : "R5/R10 casN", int'(casN), expCas);
      check("R6 weN", int'(weN), 1);
      check("R7 refReq", int'(refReq), modelReq());
      check("R2 ready", int'(ready), mStage == 2 ? 1 : 0);
      check("R9 busOwn", int'(busOwn), mBusy);
      check("R8 rowAddr", int'(rowAddr), mRow);
      check("R3 refReq backlog", int'(refReq && mStage == 2), (mBusy == 0 && mStage == 2 && mPend > 0) ? 1 : 0);
    end
  end

  // warm-up counting: owned cycles started before ready
  int warmSeen = 0;
  bit prevOwn = 0;
  bit readySeen = 0;
  always @(negedge clk) begin
    if (rstN && !readySeen) begin
      if (busOwn && !prevOwn) warmSeen++;
      if (ready) begin
        readySeen = 1;
        check("R2 warm-up cycles before ready", warmSeen, WARM);
      end
    end
    prevOwn = busOwn;
  end

  // grant policy: 0 always, 1 never, 2 every other cycle
  int policy = 0;
  bit toggleMode = 0;
  always @(negedge clk) begin
    case (policy)
      0: busGrant <= 1'b1;
      1: busGrant <= 1'b0;
      default: busGrant <= cyc[0];
    endcase
    if (toggleMode && (cyc % 3 == 0)) refMode <= ~refMode;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    policy = 0;
    refMode = 1'b0;
    waitCycles(4);
    // R1: state under reset
    check("R1 refReq in reset", int'(refReq), 0);
    check("R1 ready in reset", int'(ready), 0);
    check("R1 busOwn in reset", int'(busOwn), 0);
    check("R1 strobes in reset", int'({rasN, casN, weN}), 7);
    check("R1 rowAddr in reset", int'(rowAddr), 0);
    rstN = 1'b1;
    compareOn = 1;
    // R1: pause holds everything quiet
    waitCycles(PAUSE - 2);
    check("R1 no request during pause", int'(refReq), 0);
    check("R1 not ready during pause", int'(ready), 0);
    // warm-up and CBR normal operation
    waitCycles(WARM * LEN + 300);
    check("R2 ready after warm-up", int'(ready), 1);
    // RAS-only with row wrap (R8)
    refMode = 1'b1;
    waitCycles(IVAL * 10);
    // backlog saturation (R3)
    policy = 1;
    waitCycles(IVAL * (PMAX + 3));
    check("R3 request held with backlog", int'(refReq), 1);
    policy = 0;
    waitCycles(IVAL * 3);
    // mode changes mid-cycle (R10)
    toggleMode = 1;
    waitCycles(IVAL * 8);
    toggleMode = 0;
    // intermittent grant
    policy = 2;
    refMode = 1'b0;
    waitCycles(IVAL * 6);
    policy = 1;
    waitCycles(IVAL * 2 + 5);
    policy = 2;
    refMode = 1'b1;
    waitCycles(IVAL * 6);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule